// File: doc/BRIEF.md
# I2C Address Byte Transmitter

This block sends the first byte of an I2C master transaction: a 7-bit target address followed by the read/write bit. It then samples the target's acknowledge. It does not make SCL itself. It follows two pulses taken from the real SCL pin. One pulse marks each rising edge. The other comes a short time after each falling edge. Every SDA change is placed on the delayed pulse, so the data line never moves while SCL might still be high.

SDA is open drain. The block only asserts a pull-low enable: a 0 bit pulls the line low, and a 1 bit releases it. The line is read back on every SCL rising pulse. If the level read back differs from the bit being sent, another master has won the bus. The block then flags the loss, lets go of SDA and sits out the rest of the byte. After the ninth clock it reports either completion with an acknowledge, or completion with a missing acknowledge.

Top module: `addr_tx`

## Requirements
- R1: The address and R/W value are captured into an internal register only in a cycle where `store_i` is high. Changes on `addr_i`/`rw_i` at other times do not alter the byte that is sent.
- R2: A `start_i` pulse while idle arms the block, but SDA stays released until the next `scl_fall_dly_i` pulse. `sda_pull_o` only becomes asserted in the cycle after a delayed-fall pulse.
- R3: Bits go out MSB first: address bit 6 down to bit 0, then R/W (1 = read). A 0 bit asserts `sda_pull_o`; a 1 bit leaves it low, which releases the line.
- R4: At the delayed-fall pulse after the R/W bit, SDA is released for the acknowledge slot and stays released through it.
- R5: On the ninth SCL rising pulse, `done_o` pulses. `noack_o` pulses together with it if SDA is high at that pulse, and stays low if SDA is low.
- R6: On each rising pulse while a bit is driven, the SDA level is compared with the bit. A mismatch pulses `sda_err_o` and releases SDA in the next cycle. No further bit is driven and no `done_o` follows. The block goes idle after the ninth rising pulse of that byte.
- R7: `done_o`, `noack_o` and `sda_err_o` are single-cycle pulses. Each is registered, so it appears in the cycle after the rising pulse that caused it.
- R8: During and after reset, SDA is released, all three flags are low and the block is idle.
- R9: `start_i` has no effect while a byte is in progress. SCL pulses while idle produce no flags and drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Target address |
| rw_i | input | 1 | Transfer direction, 1 = read |
| store_i | input | 1 | Capture `addr_i` and `rw_i` |
| start_i | input | 1 | Arm transmission of the captured byte |
| scl_rise_i | input | 1 | One-cycle pulse on each SCL rising edge |
| scl_fall_dly_i | input | 1 | One-cycle pulse a delay after each SCL falling edge |
| sda_i | input | 1 | Level read back from the SDA pin |
| sda_pull_o | output | 1 | Pull SDA low |
| done_o | output | 1 | Address byte finished with an acknowledge slot |
| noack_o | output | 1 | Target did not acknowledge |
| sda_err_o | output | 1 | SDA mismatch, arbitration lost |

## Verification
The byte is sent with the following patterns:
- Alternating `0x55` and `0x2A`, each with both R/W values. These show whether bit order and polarity are right and whether R/W lands in the eighth slot.
- All-ones `0x7F` and all-zeros `0x00`. All-ones proves the line is only released and never driven; all-zeros proves the pull is held across consecutive bits.

Each of these bytes is run with the target either acknowledging or staying silent, which separates `done_o` alone from `done_o` with `noack_o`.

Three further cases are covered:
- A forced low level on a released bit mid-byte checks the arbitration path, the release that follows and the missing completion.
- Changing the address without a store checks the capture register.
- Stray start and SCL pulses show that they are ignored.

// File: rtl/addr_tx_pkg.sv
package addr_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_SEND,
    S_ACK,
    S_LOST
  } tx_state_e;
endpackage

// File: rtl/addr_tx_latch.sv
module addr_tx_latch #(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_q <= '0;
    else if (store_i) byte_q <= {addr_i, rw_i};
  end

  assign byte_o = byte_q;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(store_i) |-> $stable(byte_q)); // R1
endmodule

// File: rtl/addr_tx_bitsel.sv
module addr_tx_bitsel #(
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  // slot 0 carries the MSB
  logic [BYTE_W-1:0] ordered;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_order
    assign ordered[g] = byte_i[BYTE_W-1-g];
  end

  always_comb begin
    bit_o = 1'b1;
    for (int k = 0; k < BYTE_W; k++)
      if (idx_i == IDX_W'(k)) bit_o = ordered[k];
  end
endmodule

// File: rtl/addr_tx_ctrl.sv
module addr_tx_ctrl
  import addr_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(BYTE_W),
  localparam int RISE_W = $clog2(BYTE_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_dly_i,
  input  logic             sda_i,
  input  logic             bit_next_i,
  output logic [IDX_W-1:0] idx_next_o,
  output logic             sda_pull_o,
  output logic             done_o,
  output logic             noack_o,
  output logic             sda_err_o
);
  localparam logic [IDX_W-1:0]  LastIdx  = IDX_W'(BYTE_W - 1);
  localparam logic [RISE_W-1:0] LastRise = RISE_W'(BYTE_W);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [RISE_W-1:0] rise_q, rise_d;
  logic              cur_q, cur_d;
  logic              pull_q, pull_d;
  logic              done_q, done_d;
  logic              noack_q, noack_d;
  logic              err_q, err_d;
  logic              load;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rise_d  = rise_q;
    cur_d   = cur_q;
    pull_d  = pull_q;
    done_d  = 1'b0;
    noack_d = 1'b0;
    err_d   = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_ARM;
          rise_d  = '0;
        end
      end
      S_ARM: begin
        if (scl_fall_dly_i) begin
          idx_d   = '0;
          load    = 1'b1;
          state_d = S_SEND;
        end
      end
      S_SEND: begin
        if (scl_rise_i) begin
          rise_d = rise_q + 1'b1;
          if (sda_i != cur_q) begin
            err_d   = 1'b1;
            pull_d  = 1'b0;
            state_d = S_LOST;
          end
        end else if (scl_fall_dly_i) begin
          if (idx_q == LastIdx) begin
            pull_d  = 1'b0;
            state_d = S_ACK;
          end else begin
            idx_d = idx_q + 1'b1;
            load  = 1'b1;
          end
        end
      end
      S_ACK: begin
        if (scl_rise_i) begin
          done_d  = 1'b1;
          noack_d = sda_i;
          state_d = S_IDLE;
        end
      end
      S_LOST: begin
        if (scl_rise_i) begin
          rise_d = rise_q + 1'b1;
          if (rise_q == LastRise) state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (load) begin
      cur_d  = bit_next_i;
      pull_d = !bit_next_i;
    end
  end

  assign idx_next_o = idx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      rise_q  <= '0;
      cur_q   <= 1'b1;
      pull_q  <= 1'b0;
      done_q  <= 1'b0;
      noack_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rise_q  <= rise_d;
      cur_q   <= cur_d;
      pull_q  <= pull_d;
      done_q  <= done_d;
      noack_q <= noack_d;
      err_q   <= err_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign done_o     = done_q;
  assign noack_o    = noack_q;
  assign sda_err_o  = err_q;

  AST_PULL_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> $past(scl_fall_dly_i)); // R2
  AST_RELEASE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_q) |-> ($past(scl_fall_dly_i) || $past(scl_rise_i))); // R6
  AST_ACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ACK) |-> !pull_q); // R4
  AST_LOST_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !pull_q); // R6
  AST_NOACK_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noack_q |-> done_q); // R5
  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_q && done_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q); // R7
  AST_FLAG_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || err_q) |-> $past(scl_rise_i)); // R7
endmodule

// File: rtl/addr_tx.sv
module addr_tx #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic              store_i,
  input  logic              start_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_dly_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              done_o,
  output logic              noack_o,
  output logic              sda_err_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int IDX_W  = $clog2(BYTE_W);

  logic [BYTE_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_next;
  logic              bit_next;

  addr_tx_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .store_i (store_i),
    .addr_i  (addr_i),
    .rw_i    (rw_i),
    .byte_o  (byte_q)
  );

  addr_tx_bitsel #(.BYTE_W(BYTE_W)) u_bitsel (
    .byte_i (byte_q),
    .idx_i  (idx_next),
    .bit_o  (bit_next)
  );

  addr_tx_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .scl_rise_i     (scl_rise_i),
    .scl_fall_dly_i (scl_fall_dly_i),
    .sda_i          (sda_i),
    .bit_next_i     (bit_next),
    .idx_next_o     (idx_next),
    .sda_pull_o     (sda_pull_o),
    .done_o         (done_o),
    .noack_o        (noack_o),
    .sda_err_o      (sda_err_o)
  );
endmodule

// File: tb/addr_tx_test.sv
module addr_tx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] addr = '0;
  logic       rw = 1'b0;
  logic       store = 1'b0;
  logic       start = 1'b0;
  logic       rise = 1'b0;
  logic       fall = 1'b0;
  logic       ext_low = 1'b0;
  logic       sda;
  logic       pull, done, noack, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] model_byte = '0;

  logic       bit_q[$];   // expected released level at each rising pulse
  logic [2:0] evt_q[$];   // expected {done, noack, err}

  always #5 clk = ~clk;

  assign sda = !(pull || ext_low);

  addr_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rw_i(rw), .store_i(store),
    .start_i(start), .scl_rise_i(rise), .scl_fall_dly_i(fall), .sda_i(sda),
    .sda_pull_o(pull), .done_o(done), .noack_o(noack), .sda_err_o(err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    idle(1);
    s = 1'b0;
  endtask

  task automatic store_byte(input logic [6:0] a, input logic r);
    addr = a; rw = r; store = 1'b1;
    idle(1);
    store = 1'b0;
    model_byte = {a, r};
  endtask

  // lose: slot index where the bench forces SDA low on a 1 bit, -1 for none
  task automatic send_byte(input bit ack, input int lose, input bit stray_start);
    bit lost = 1'b0;
    for (int k = 0; k < 9; k++) begin
      if (lost || k == 8) bit_q.push_back(1'b1);
      else bit_q.push_back(model_byte[7-k]);
      if (k == lose) lost = 1'b1;
    end
    if (lose >= 0) evt_q.push_back(3'b001);
    else evt_q.push_back({1'b1, !ack, 1'b0});
    pulse(start);
    idle(2);
    @(negedge clk);
    check("R2 no drive before first delayed fall", {7'd0, pull}, 8'd0);
    idle(1);
    pulse(fall);
    idle(1);
    @(negedge clk);
    check("R2 first bit on delayed fall", {7'd0, pull}, {7'd0, (lose == 0) ? 1'b0 : !model_byte[7]});
    idle(1);
    for (int k = 0; k < 9; k++) begin
      ext_low = (k == lose) || (k == 8 && ack);
      idle(1);
      pulse(rise);
      idle(1);
      ext_low = 1'b0;
      if (stray_start && k == 3) pulse(start); // R9 ignored while busy
      idle(1);
      pulse(fall);
      idle(2);
    end
    idle(3);
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (rise && bit_q.size() > 0) begin
        logic e;
        e = bit_q.pop_front();
        check("R3 bit level at rising pulse", {7'd0, !pull}, {7'd0, e});
      end
      if (done || noack || err) begin
        if (evt_q.size() == 0) check("R5 unexpected flag", {5'd0, done, noack, err}, 8'd0);
        else check("R5 R6 R7 flag set", {5'd0, done, noack, err}, {5'd0, evt_q.pop_front()});
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    summary();
  end

  initial begin
    idle(2);
    @(negedge clk);
    check("R8 pull in reset", {7'd0, pull}, 8'd0);
    check("R8 flags in reset", {5'd0, done, noack, err}, 8'd0);
    rst_ni = 1'b1;
    idle(2);
    @(negedge clk);
    check("R8 pull after reset", {7'd0, pull}, 8'd0);
    check("R8 flags after reset", {5'd0, done, noack, err}, 8'd0);

    // R3 R5 patterns
    store_byte(7'h55, 1'b0); send_byte(1'b1, -1, 1'b0);
    store_byte(7'h2A, 1'b1); send_byte(1'b0, -1, 1'b0);
    store_byte(7'h7F, 1'b1); send_byte(1'b1, -1, 1'b0);
    store_byte(7'h00, 1'b0); send_byte(1'b0, -1, 1'b0);
    store_byte(7'h2A, 1'b0); send_byte(1'b1, -1, 1'b1);

    // R1 address change without store
    store_byte(7'h13, 1'b1);
    addr = 7'h6C; rw = 1'b0;
    send_byte(1'b1, -1, 1'b0);

    // R6 arbitration loss on slot 2 (bit value 1 in 0x55)
    store_byte(7'h55, 1'b1); send_byte(1'b1, 2, 1'b0);
    // R6 recovery: next byte completes normally
    send_byte(1'b1, -1, 1'b0);

    // R9 pulses while idle
    ext_low = 1'b1;
    pulse(rise); idle(1); pulse(fall); idle(2);
    ext_low = 1'b0;
    @(negedge clk);
    check("R9 idle pulses drive nothing", {7'd0, pull}, 8'd0);

    idle(3);
    check("R5 pending events", 8'(evt_q.size()), 8'd0);
    check("R3 pending bits", 8'(bit_q.size()), 8'd0);
    summary();
  end
endmodule